// File: doc/BRIEF.md
# Control Word Majority-Vote Decoder

This block sits on the receive side of a DC-balanced serial video link, behind a deframer that has already found word boundaries and removed the line coding. Each cycle the deframer may present one aligned 20-bit word with a valid strobe and a two-bit phase tag. Control words carry nine control bits. Five of them are sent three times each and are recovered here by a 2-of-3 vote, so a single corrupted copy is tolerated. The other four are sent once and are passed straight through. Video words carry an 18-bit payload that is already decoded.

The control outputs change only on control words, and the video outputs change only on video words. Each output holds its last value through every other phase. A data-enable output is rebuilt from the phase tag. A one-cycle error pulse reports any triple whose copies disagree, so upstream logic can watch link quality. Every output is a flop, one cycle behind the word it reflects.

Top module: `ctl_vote_decoder`

## Requirements
- R1: While rst_ni is low, ctl_o, video_o, de_o and err_o are all zero; the reset is asynchronous.
- R2: Phase codes are 0 = control, 1 = video, 2 = transition, and 3 = reserved (handled like transition). On a valid control word, ctl_o[k] for k = 0..4 becomes the value held by at least two of word bits 1+3k, 2+3k and 3+3k.
- R3: Flipping any single bit inside one triple of a control word leaves the recovered ctl_o unchanged. Flipping two bits of one triple inverts that bit.
- R4: On a valid control word, ctl_o[5+j] for j = 0..3 is taken directly from word bit 16+j, with no voting.
- R5: Word bit 0 of a control word has no effect on ctl_o or err_o.
- R6: ctl_o holds its value after valid words tagged video, transition or reserved.
- R7: On a valid video word, video_o becomes word bits 19..2. video_o holds after every other valid word.
- R8: After each valid word, de_o is 1 if the word was tagged video and 0 otherwise.
- R9: err_o is high for exactly the cycle after a valid control word in which at least one triple has disagreeing copies. It is low in every other cycle.
- R10: Outputs update one clock edge after the strobed word. With word_valid_i low, ctl_o, video_o and de_o hold and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Strobe: word_i and phase_i are valid this cycle |
| phase_i | input | 2 | Phase tag: 0 control, 1 video, 2 transition, 3 reserved |
| word_i | input | 20 | Aligned, decoded 20-bit word |
| ctl_o | output | 9 | Recovered control bits, held outside control phase |
| video_o | output | 18 | Video payload, held outside video phase |
| de_o | output | 1 | Data enable, high after video words |
| err_o | output | 1 | One-cycle pulse on a disagreeing triple |

## Verification
The bench uses the default parameters: five voted bits, four direct bits and two video header bits, which give the full 20-bit word. With these values, every bit position of the word can be reached by a single-bit flip. The flips cover the first copy of C0, copies inside middle and last triples, the unused bit 0, and a direct bit. This separates voted bits from pass-through bits. A double flip inside one triple, a reserved phase code, idle cycles with changing inputs and a mid-run asynchronous reset cover the remaining hold and override paths.

// File: rtl/ctl_vote_pkg.sv
package ctl_vote_pkg;
  typedef enum logic [1:0] {
    PH_CTRL  = 2'd0,
    PH_VIDEO = 2'd1,
    PH_TRANS = 2'd2,
    PH_RSVD  = 2'd3
  } phase_e;
endpackage

// File: rtl/ctl_vote_maj3.sv
module ctl_vote_maj3 (
  input  logic [2:0] copies_i,
  output logic       bit_o,
  output logic       split_o
);
  always_comb begin
    bit_o   = (copies_i[0] & copies_i[1]) | (copies_i[1] & copies_i[2]) |
              (copies_i[0] & copies_i[2]);
    split_o = ~((&copies_i) | ~(|copies_i));
  end

  // R3
  always_comb begin
    if (copies_i[0] == copies_i[2]) maj_pair_chk: assert (bit_o == copies_i[0]);
  end
endmodule

// File: rtl/ctl_vote_extract.sv
module ctl_vote_extract #(
  parameter int VOTED_N  = 5,
  parameter int DIRECT_N = 4,
  localparam int CTL_W   = VOTED_N + DIRECT_N,
  localparam int WORD_W  = 1 + 3 * VOTED_N + DIRECT_N
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              split_o
);
  logic [VOTED_N-1:0] split_v;

  for (genvar k = 0; k < VOTED_N; k++) begin : g_vote
    ctl_vote_maj3 u_maj (
      .copies_i (word_i[1 + 3 * k +: 3]),
      .bit_o    (ctl_o[k]),
      .split_o  (split_v[k])
    );
  end

  for (genvar j = 0; j < DIRECT_N; j++) begin : g_direct
    assign ctl_o[VOTED_N + j] = word_i[1 + 3 * VOTED_N + j];
  end

  assign split_o = |split_v;
endmodule

// File: rtl/ctl_vote_decoder.sv
module ctl_vote_decoder
  import ctl_vote_pkg::*;
#(
  parameter int VOTED_N  = 5,
  parameter int DIRECT_N = 4,
  parameter int ENC_W    = 2,
  localparam int CTL_W   = VOTED_N + DIRECT_N,
  localparam int WORD_W  = 1 + 3 * VOTED_N + DIRECT_N,
  localparam int VID_W   = WORD_W - ENC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [1:0]        phase_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [VID_W-1:0]  video_o,
  output logic              de_o,
  output logic              err_o
);
  logic [CTL_W-1:0] ctl_dec;
  logic             split_any;
  logic             take_ctl, take_vid;

  ctl_vote_extract #(.VOTED_N(VOTED_N), .DIRECT_N(DIRECT_N)) u_extract (
    .word_i  (word_i),
    .ctl_o   (ctl_dec),
    .split_o (split_any)
  );

  assign take_ctl = word_valid_i && (phase_e'(phase_i) == PH_CTRL);
  assign take_vid = word_valid_i && (phase_e'(phase_i) == PH_VIDEO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o   <= '0;
      video_o <= '0;
      de_o    <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      err_o <= take_ctl && split_any;
      if (take_ctl) ctl_o <= ctl_dec;
      if (take_vid) video_o <= word_i[WORD_W-1:ENC_W];
      if (word_valid_i) de_o <= take_vid;
    end
  end

  // R6
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && phase_i != PH_CTRL) |=> $stable(ctl_o));

  // R7
  video_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_i && phase_i == PH_VIDEO) |=> $stable(video_o));

  // R8
  de_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && phase_i == PH_VIDEO) |=> de_o);

  // R9
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_i && phase_i == PH_CTRL) |=> !err_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> ($stable(ctl_o) && $stable(de_o) && !err_o));
endmodule

// File: tb/ctl_vote_decoder_tb.sv
module ctl_vote_decoder_tb;
  import ctl_vote_pkg::*;

  localparam int CTL_W  = 9;
  localparam int WORD_W = 20;
  localparam int VID_W  = 18;

  typedef struct packed {
    logic        vld;
    logic [1:0]  ph;
    logic [17:0] d;
    logic [4:0]  flip;  // 31 = none
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 18'h001ff, 5'd31},
    '{1'b1, 2'd0, 18'h000a5, 5'd1},
    '{1'b1, 2'd0, 18'h0015a, 5'd9},
    '{1'b1, 2'd0, 18'h00000, 5'd14},
    '{1'b1, 2'd0, 18'h00123, 5'd0},
    '{1'b1, 2'd0, 18'h000f0, 5'd17},
    '{1'b1, 2'd2, 18'h3ffff, 5'd31},
    '{1'b1, 2'd1, 18'h2aaaa, 5'd31},
    '{1'b1, 2'd1, 18'h15555, 5'd31},
    '{1'b0, 2'd0, 18'h00000, 5'd31},
    '{1'b1, 2'd2, 18'h00000, 5'd31},
    '{1'b1, 2'd0, 18'h001e1, 5'd7},
    '{1'b1, 2'd3, 18'h12345, 5'd31},
    '{1'b1, 2'd1, 18'h00001, 5'd31}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              word_valid_i = 1'b0;
  logic [1:0]        phase_i = 2'd0;
  logic [WORD_W-1:0] word_i = '0;
  logic [CTL_W-1:0]  ctl_o;
  logic [VID_W-1:0]  video_o;
  logic              de_o, err_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [CTL_W-1:0] exp_ctl = '0;
  logic [VID_W-1:0] exp_vid = '0;
  logic             exp_de = 1'b0, exp_err = 1'b0;

  always #2 clk = ~clk;

  ctl_vote_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_valid_i(word_valid_i), .phase_i(phase_i),
    .word_i(word_i), .ctl_o(ctl_o), .video_o(video_o), .de_o(de_o), .err_o(err_o)
  );

  function automatic logic [WORD_W-1:0] mk_ctl(logic [CTL_W-1:0] c);
    logic [WORD_W-1:0] w = '0;
    w[0] = 1'b1;
    for (int k = 0; k < 5; k++) w[1+3*k +: 3] = {3{c[k]}};
    for (int j = 0; j < 4; j++) w[16+j] = c[5+j];
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model(logic v, logic [1:0] ph, logic [WORD_W-1:0] w);
    exp_err = 1'b0;
    if (!v) return;
    exp_de = (ph == 2'd1);
    if (ph == 2'd1) exp_vid = w[19:2];
    if (ph == 2'd0) begin
      for (int k = 0; k < 5; k++) begin
        int cnt = int'(w[1+3*k]) + int'(w[2+3*k]) + int'(w[3+3*k]);
        exp_ctl[k] = (cnt >= 2);
        if (cnt == 1 || cnt == 2) exp_err = 1'b1;
      end
      for (int j = 0; j < 4; j++) exp_ctl[5+j] = w[16+j];
    end
  endtask

  task automatic step(logic v, logic [1:0] ph, logic [WORD_W-1:0] w, string ctag);
    word_valid_i = v;
    phase_i      = ph;
    word_i       = w;
    model(v, ph, w);
    @(negedge clk);
    chk(ctag, 32'(ctl_o), 32'(exp_ctl));
    chk("R7 video", 32'(video_o), 32'(exp_vid));
    chk("R8 de", 32'(de_o), 32'(exp_de));
    chk("R9 err", 32'(err_o), 32'(exp_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ctl", 32'(ctl_o), 0);
    chk("R1 video", 32'(video_o), 0);
    chk("R1 de", 32'(de_o), 0);
    chk("R1 err", 32'(err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t e = VECS[i];
      logic [WORD_W-1:0] w;
      w = (e.ph == 2'd0) ? mk_ctl(e.d[8:0]) : {e.d, 2'b10};
      if (e.flip != 5'd31) w[e.flip] = ~w[e.flip];
      if (!e.vld) w = 20'hfffff;
      step(e.vld, e.ph, w,
           (e.vld && e.ph == 2'd0) ? "R2 R3 R4 R5 ctl" :
           (e.vld ? "R6 ctl hold" : "R10 idle ctl"));
    end

    // R3: two copies flipped inverts C2
    begin
      logic [WORD_W-1:0] w = mk_ctl(9'h004);
      w[7] = 1'b0; w[8] = 1'b0;
      step(1'b1, 2'd0, w, "R3 double flip");
      chk("R3 C2 inverted", 32'(ctl_o[2]), 0);
    end

    // R10: idle cycles with changing inputs
    for (int i = 0; i < 3; i++) step(1'b0, 2'(i), 20'h5a5a5 ^ 20'(i), "R10 idle");

    // R4: direct bits only
    step(1'b1, 2'd0, mk_ctl(9'h1e0), "R4 direct");

    // R1: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    chk("R1 async ctl", 32'(ctl_o), 0);
    chk("R1 async de", 32'(de_o), 0);
    chk("R1 async video", 32'(video_o), 0);
    exp_ctl = '0; exp_vid = '0; exp_de = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b1, 2'd1, 20'habcde, "R6 after reset");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule